// File: doc/BRIEF.md
# Rotating-Bar Test Pattern Generator

This block produces one complete frame of traffic for a parallel display controller each time it is launched. A frame opens with a window-setup preamble: a column-window command with four byte-wide arguments, a row-window command with four arguments, and a memory-write command. The pixel words that follow cover the whole screen, row by row.

The picture is a set of vertical stripes. Every pixel word holds exactly one set bit. That bit moves one position toward the LSB every eight columns, and it wraps back to the MSB when it falls off the bottom. Every row restarts from the frame's start mask. The start mask advances by one bit position on each completed frame, so repeated frames make the bars appear to rotate.

Words leave through a valid/ready handshake and carry a command/data flag. A chip-select output frames the whole transfer, and a single-cycle done pulse marks the end of each frame. Screen width, screen height and word width are parameters.

Top module: `bar_pattern_gen`

## Requirements
- R1: After reset, out_valid, out_cs and frame_done are low and the internal frame counter is zero, so the first frame's start mask is 0x0001.
- R2: A frame begins with 11 preamble words, each accepted in turn:
  - command 0x2A with out_is_cmd=1;
  - data 0x00 and 0x00;
  - data (SCR_W-1)[15:8] and (SCR_W-1)[7:0];
  - command 0x2B;
  - data 0x00 and 0x00;
  - data (SCR_H-1)[15:8] and (SCR_H-1)[7:0];
  - command 0x2C.

  Data bytes sit in bits 7:0 of out_data, and the upper bits are zero.
- R3: After the preamble come exactly SCR_W*SCR_H pixel words with out_is_cmd=0, in row-major order. Each row starts from the frame's start mask.
- R4: For a pixel whose column index has its low three bits equal to 7, the running mask is shifted right by one bit before that pixel is emitted. Other columns repeat the previous pixel's mask.
- R5: When that shift leaves the mask at zero, the mask reloads to 0x8000 (only the MSB set).
- R6: The start mask of frame k after reset is 1 << (k mod 16). The counter advances once per completed frame and wraps from 15 to 0.
- R7: A word advances only on a cycle with out_valid and out_ready both high. While out_valid is high and out_ready is low, out_data and out_is_cmd hold, so nothing is dropped or repeated.
- R8: out_cs is high from the first preamble word through the last pixel word, and it falls in the cycle after the last pixel is accepted.
- R9: frame_done is a one-cycle pulse in the cycle right after the last pixel word is accepted.
- R10: frame_start is acted on only while idle, and the preamble appears on the next cycle. A frame_start during a frame has no effect on the stream and does not queue another frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Launch one frame when idle |
| out_ready | input | 1 | Downstream accepts the current word |
| out_valid | output | 1 | Current word is valid (write strobe) |
| out_cs | output | 1 | Chip select for the whole frame transfer |
| out_is_cmd | output | 1 | 1 = command word, 0 = data/pixel word |
| out_data | output | WORD_W | Command code, argument byte or pixel word |
| frame_done | output | 1 | One-cycle pulse after the last pixel is accepted |

## Verification
The bench builds the block with SCR_W=260 and SCR_H=2.

A last column of 259 gives a non-zero high argument byte (0x01) in the column window. A width that is not a multiple of eight ends each row partway through a stripe. With 260 columns the running mask also wraps from the LSB to the MSB twice per row.

Two rows keep each frame short enough to run seventeen frames under changing backpressure patterns. That carries the start mask through its full cycle and back to 0x0001.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_PIX  = 2'd2
    } gen_state_e;

    localparam int PRE_LEN = 11;
    localparam int PRE_IW  = 4;

    localparam logic [7:0] CMD_COL_WIN = 8'h2A;
    localparam logic [7:0] CMD_ROW_WIN = 8'h2B;
    localparam logic [7:0] CMD_MEM_WR  = 8'h2C;
endpackage

// File: rtl/bpg_preamble.sv
module bpg_preamble #(
    parameter int SCR_W = 480,
    parameter int SCR_H = 272
) (
    input  logic [bpg_pkg::PRE_IW-1:0] idx,
    output logic                       is_cmd,
    output logic [7:0]                 pre_byte
);
    localparam logic [15:0] LAST_COL = 16'(SCR_W - 1);
    localparam logic [15:0] LAST_ROW = 16'(SCR_H - 1);

    always_comb begin
        is_cmd   = 1'b0;
        pre_byte = 8'h00;
        case (idx)
            4'd0: begin is_cmd = 1'b1; pre_byte = bpg_pkg::CMD_COL_WIN; end
            4'd3: pre_byte = LAST_COL[15:8];
            4'd4: pre_byte = LAST_COL[7:0];
            4'd5: begin is_cmd = 1'b1; pre_byte = bpg_pkg::CMD_ROW_WIN; end
            4'd8: pre_byte = LAST_ROW[15:8];
            4'd9: pre_byte = LAST_ROW[7:0];
            4'd10: begin is_cmd = 1'b1; pre_byte = bpg_pkg::CMD_MEM_WR; end
            default: begin is_cmd = 1'b0; pre_byte = 8'h00; end
        endcase
    end
endmodule

// File: rtl/bpg_stripe.sv
module bpg_stripe #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] held,
    input  logic [2:0]        col_lo,
    output logic [WORD_W-1:0] pix
);
    localparam logic [WORD_W-1:0] TOP_BIT = {1'b1, {(WORD_W-1){1'b0}}};

    logic [WORD_W-1:0] shifted;

    always_comb begin
        shifted = held >> 1;
        if (col_lo == 3'd7) begin
            pix = (shifted == '0) ? TOP_BIT : shifted;
        end else begin
            pix = held;
        end
    end
endmodule

// File: rtl/bar_pattern_gen.sv
module bar_pattern_gen #(
    parameter int SCR_W  = 480,
    parameter int SCR_H  = 272,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              out_ready,
    output logic              out_valid,
    output logic              out_cs,
    output logic              out_is_cmd,
    output logic [WORD_W-1:0] out_data,
    output logic              frame_done
);
    import bpg_pkg::*;

    localparam int CW = (SCR_W > 1) ? $clog2(SCR_W) : 1;
    localparam int RW = (SCR_H > 1) ? $clog2(SCR_H) : 1;
    localparam int FW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CW-1:0]     LAST_C   = CW'(SCR_W - 1);
    localparam logic [RW-1:0]     LAST_R   = RW'(SCR_H - 1);
    localparam logic [FW-1:0]     LAST_F   = FW'(WORD_W - 1);
    localparam logic [PRE_IW-1:0] LAST_PRE = PRE_IW'(PRE_LEN - 1);

    typedef struct packed {
        gen_state_e        st;
        logic [PRE_IW-1:0] pre_idx;
        logic [CW-1:0]     col;
        logic [RW-1:0]     row;
        logic [WORD_W-1:0] mask;
        logic [FW-1:0]     fcnt;
        logic              done;
    } gen_regs_t;

    gen_regs_t r_q, r_d;

    logic              pre_cmd;
    logic [7:0]        pre_byte;
    logic [WORD_W-1:0] pix_word;
    logic [WORD_W-1:0] start_mask;
    logic              accept;

    bpg_preamble #(.SCR_W(SCR_W), .SCR_H(SCR_H)) u_pre (
        .idx      (r_q.pre_idx),
        .is_cmd   (pre_cmd),
        .pre_byte (pre_byte)
    );

    bpg_stripe #(.WORD_W(WORD_W)) u_stripe (
        .held   (r_q.mask),
        .col_lo (3'(r_q.col)),
        .pix    (pix_word)
    );

    assign start_mask = WORD_W'(1) << r_q.fcnt;
    assign out_valid  = (r_q.st != ST_IDLE);
    assign out_cs     = (r_q.st == ST_PRE) || (r_q.st == ST_PIX);
    assign out_is_cmd = (r_q.st == ST_PRE) && pre_cmd;
    assign out_data   = (r_q.st == ST_PRE) ? WORD_W'(pre_byte) : pix_word;
    assign frame_done = r_q.done;
    assign accept     = out_valid && out_ready;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (frame_start) begin
                    r_d.st      = ST_PRE;
                    r_d.pre_idx = '0;
                    r_d.col     = '0;
                    r_d.row     = '0;
                    r_d.mask    = start_mask;
                end
            end
            ST_PRE: begin
                if (accept) begin
                    if (r_q.pre_idx == LAST_PRE) begin
                        r_d.st = ST_PIX;
                    end else begin
                        r_d.pre_idx = r_q.pre_idx + 1'b1;
                    end
                end
            end
            ST_PIX: begin
                if (accept) begin
                    r_d.mask = pix_word;
                    if (r_q.col == LAST_C) begin
                        r_d.col  = '0;
                        r_d.mask = start_mask;
                        if (r_q.row == LAST_R) begin
                            r_d.st   = ST_IDLE;
                            r_d.done = 1'b1;
                            r_d.fcnt = (r_q.fcnt == LAST_F) ? '0 : r_q.fcnt + 1'b1;
                        end else begin
                            r_d.row = r_q.row + 1'b1;
                        end
                    end else begin
                        r_d.col = r_q.col + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st      <= ST_IDLE;
            r_q.pre_idx <= '0;
            r_q.col     <= '0;
            r_q.row     <= '0;
            r_q.mask    <= '0;
            r_q.fcnt    <= '0;
            r_q.done    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    // R7: a stalled word stays put
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_is_cmd));

    // R9: done lasts exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R8: chip select has dropped when done is reported, and was high before
    a_r8_cs_drop: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !out_cs && $past(out_cs));

    // R2: a new transfer always opens with the column-window command
    a_r2_open_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_cs) |-> out_is_cmd && (out_data == WORD_W'(CMD_COL_WIN)));

    // R3: every pixel word carries exactly one set bit
    a_r3_onehot_pix: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PIX) |-> !out_is_cmd && $onehot(out_data));

    // R10: a launch from idle shows a word on the next cycle
    a_r10_launch: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && frame_start |=> out_valid);
endmodule

// File: tb/tb_bar_pattern_gen.sv
module tb_bar_pattern_gen;
    localparam int W      = 260;
    localparam int H      = 2;
    localparam int WW     = 16;
    localparam int NPRE   = 11;
    localparam int TOTAL  = NPRE + W * H;
    localparam int NFRAME = 17;

    // {is_cmd, data} expected for the preamble, walked in order
    localparam logic [16:0] PRE_TBL [NPRE] = '{
        {1'b1, 16'h002A}, {1'b0, 16'h0000}, {1'b0, 16'h0000},
        {1'b0, 16'h0001}, {1'b0, 16'h0003},
        {1'b1, 16'h002B}, {1'b0, 16'h0000}, {1'b0, 16'h0000},
        {1'b0, 16'h0000}, {1'b0, 16'h0001},
        {1'b1, 16'h002C}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          out_ready = 1'b0;
    logic          out_valid, out_cs, out_is_cmd, frame_done;
    logic [WW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] lf = 8'h5B;

    bar_pattern_gen #(.SCR_W(W), .SCR_H(H), .WORD_W(WW)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .out_ready(out_ready),
        .out_valid(out_valid), .out_cs(out_cs), .out_is_cmd(out_is_cmd),
        .out_data(out_data), .frame_done(frame_done)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual cycles=%0d expected <=150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_pix(input int col, input int fk);
        logic [15:0] m;
        m = 16'h0001 << (fk % 16);
        for (int j = 0; j <= col; j++) begin
            if ((j & 7) == 7) begin
                m = m >> 1;
                if (m == 16'h0000) m = 16'h8000;
            end
        end
        return m;
    endfunction

    task automatic run_frame(input int fk, input int mode, input bit poke);
        int idx = 0;
        logic [15:0] prev_data = '0;
        logic        prev_cmd = 1'b0;
        logic        stalled = 1'b0;
        logic [16:0] e;
        @(negedge clk);
        frame_start = 1'b1;
        out_ready = 1'b0;
        @(negedge clk);
        frame_start = 1'b0;
        chk("R10 launch valid", 32'(out_valid), 32'd1);
        while (idx < TOTAL) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            case (mode)
                0: out_ready = 1'b1;
                1: out_ready = lf[0];
                default: out_ready = ~out_ready;
            endcase
            frame_start = (poke && idx == 30) ? 1'b1 : 1'b0;
            if (stalled) begin
                chk("R7 hold data", 32'(out_data), 32'(prev_data));
                chk("R7 hold flag", 32'(out_is_cmd), 32'(prev_cmd));
            end
            chk("R8 cs during frame", 32'(out_cs), 32'd1);
            stalled = out_valid && !out_ready;
            prev_data = out_data;
            prev_cmd = out_is_cmd;
            if (out_valid && out_ready) begin
                if (idx < NPRE) begin
                    e = PRE_TBL[idx];
                    chk("R2 preamble flag", 32'(out_is_cmd), 32'(e[16]));
                    chk("R2 preamble word", 32'(out_data), 32'(e[15:0]));
                end else begin
                    chk("R3 pixel flag", 32'(out_is_cmd), 32'd0);
                    chk("R3 R4 R5 R6 pixel", 32'(out_data),
                        32'(exp_pix((idx - NPRE) % W, fk)));
                end
                idx++;
            end
            @(negedge clk);
        end
        frame_start = 1'b0;
        chk("R9 done pulse", 32'(frame_done), 32'd1);
        chk("R8 cs low after last", 32'(out_cs), 32'd0);
        @(negedge clk);
        chk("R9 done single cycle", 32'(frame_done), 32'd0);
        chk("R10 no queued frame", 32'(out_valid), 32'd0);
        @(negedge clk);
        chk("R10 still idle", 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid after reset", 32'(out_valid), 32'd0);
        chk("R1 cs after reset", 32'(out_cs), 32'd0);
        chk("R1 done after reset", 32'(frame_done), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle without start", 32'(out_valid), 32'd0);
        // directed corner values of the model itself, per requirement
        chk("R1 first start mask", 32'(exp_pix(0, 0)), 32'h0001);
        chk("R4 shift at column 7", 32'(exp_pix(7, 3)), 32'h0004);
        chk("R5 wrap to top bit", 32'(exp_pix(7, 0)), 32'h8000);
        chk("R6 counter wraps", 32'(exp_pix(0, 16)), 32'h0001);
        for (int k = 0; k < NFRAME; k++) begin
            run_frame(k, k % 3, (k == 3));
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule